// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Interrupt Detection

This block is an 8-bit general-purpose I/O port with a small register interface. Software reads and writes it through a single-cycle write strobe and a combinational read port. A data register and a direction register drive the pad-side output and output-enable buses. Reads of the data location return the register value for output pins and the synchronized pin level for input pins.

Each pin also has an interrupt detector. One bit-plane picks level or edge sensing and another picks polarity: active-low or falling, against active-high or rising. Edge events are held in a latch until software clears them by writing ones to an acknowledge location. Level conditions are never latched and follow the pin. An enable plane gates every pin's pending state. An optional per-pin debounce filter sits in front of the detector. Every pin input first passes through a two-flop synchronizer.

The gated pending state is presented three ways: as a readable status register, as one interrupt output per pin, and as a single combined output. The combined output serves ports whose pins share one interrupt line. There is no both-edge mode. Software emulates it by flipping a pin's polarity bit after each event, and the detector then waits for the opposite edge from that cycle onward.

Top module: `gpio_irq_bank`

## Requirements
- R1: Each pin input passes through two flops before it reaches the data read path or the detector. A change at `pin_in` is visible in a data-register read after the second rising clock edge.
- R2: Byte offsets are data 0x00, direction 0x10, edge-select 0x90, polarity 0x94, acknowledge 0x98 (write-only, reads 0), enable 0x9C, status 0xA0 (read-only), and debounce 0xA8. Any other offset reads 0. The synchronous active-high reset clears every register and latch to 0.
- R3: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the data register. A data read returns `(data & dir) | (sync_pin & ~dir)`.
- R4: With edge-select bit 0 the pin is level-sensitive. Polarity 1 means active-high and 0 means active-low. A level pending bit follows the pin and an acknowledge write does not clear it.
- R5: With edge-select bit 1, a rising edge (polarity 1) or a falling edge (polarity 0) of the detector input sets the pin's latched event one clock after the detector input changes. The event stays set after the pin returns.
- R6: Writing the acknowledge register clears the latched event of each bit written as 1. Bits written as 0 keep their event. A new edge in the same cycle as the clear wins.
- R7: Status bit i equals enable bit i AND the pin's pending condition. Writing 0 to the enable register forces all interrupt outputs to 0.
- R8: Changing the polarity bit of an edge-configured pin makes it respond to the opposite edge from the next clock onward.
- R9: With debounce bit i set, the detector sees a new level only after the synchronized pin has held that level for DB_CYCLES consecutive clocks (default 4). Shorter pulses are dropped.
- R10: `irq_pin` equals the status register and `irq_comb` is the OR of its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output levels to the pads |
| pin_oe | output | 8 | Output enables, 1 means drive |
| irq_pin | output | 8 | Per-pin interrupt outputs |
| irq_comb | output | 1 | Combined interrupt output |

## Verification
The bench targets the cycle of latency through the synchronizer and the edge register. A design with one flop too few or too many would assert its interrupts a cycle off the reference on every clock.

Several corner cases get their own stimulus:
- An acknowledge write with zero bits next to a live event checks that a design clearing the whole latch is caught.
- Pulses shorter than the debounce window check the filter; a design with no filter would fire on them.
- A level-sensitive pin is acknowledged while still active. A design that latched level conditions would keep the interrupt after the pin returned, or drop it while the pin was still active.
- A polarity flip between two edges checks that detection retargets; a design that kept rising-only detection would miss the falling edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int GPIO_W = 8;
    localparam int ADDR_W = 8;

    typedef logic [GPIO_W-1:0] gvec_t;

    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EDGE = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_DBNC = 8'hA8;

    typedef struct packed {
        gvec_t data;
        gvec_t dir;
        gvec_t edge_sel;
        gvec_t rise_high;
        gvec_t enable;
        gvec_t dbnc;
    } port_cfg_t;

    // Bits where the selected edge occurred between prev and cur.
    function automatic gvec_t edge_hits(gvec_t cur, gvec_t prev,
                                        gvec_t edge_sel, gvec_t rise);
        return edge_sel & ((rise & cur & ~prev) | (~rise & ~cur & prev));
    endfunction

    // Bits whose level matches the active polarity.
    function automatic gvec_t level_hits(gvec_t cur, gvec_t rise);
        return ~(cur ^ rise);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int W         = 8,
    parameter int DB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CNT_W = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [CNT_W-1:0] run_cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                run_cnt <= '0;
                dout[i] <= 1'b0;
            end else if (din[i] == dout[i]) begin
                run_cnt <= '0;
            end else if (run_cnt == CNT_LAST) begin
                run_cnt <= '0;
                dout[i] <= din[i];
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end

        // R9: the filtered level only moves to a value the input already held
        assert_filter_follows_R9: assert property (@(posedge clk) disable iff (rst)
            (dout[i] != $past(dout[i])) |-> ($past(din[i]) == dout[i]));
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  gvec_t raw_lvl,
    input  gvec_t filt_lvl,
    input  gvec_t dbnc,
    input  gvec_t edge_sel,
    input  gvec_t rise_high,
    input  gvec_t enable,
    input  gvec_t ack_clr,
    output gvec_t status
);
    gvec_t det_lvl;
    gvec_t prev_lvl;
    gvec_t edge_evt;
    gvec_t evt_latch;
    gvec_t pending;

    always_comb begin
        det_lvl  = (dbnc & filt_lvl) | (~dbnc & raw_lvl);
        edge_evt = edge_hits(det_lvl, prev_lvl, edge_sel, rise_high);
        pending  = (edge_sel & evt_latch) | (~edge_sel & level_hits(det_lvl, rise_high));
        status   = enable & pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl  <= '0;
            evt_latch <= '0;
        end else begin
            prev_lvl  <= det_lvl;
            evt_latch <= (evt_latch & ~ack_clr) | edge_evt;
        end
    end

    // R5: a detected edge is held in the latch on the following cycle
    assert_edge_latched_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_latch & $past(edge_evt)) == $past(edge_evt));

    // R6: acknowledged bits without a fresh edge are cleared
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_latch & $past(ack_clr & ~edge_evt)) == '0);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int DB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic [GPIO_W-1:0] irq_pin,
    output logic              irq_comb
);
    port_cfg_t cfg;
    gvec_t     pin_sync;
    gvec_t     pin_filt;
    gvec_t     ack_clr;
    gvec_t     status;

    gpio_sync #(.W(GPIO_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    gpio_debounce #(.W(GPIO_W), .DB_CYCLES(DB_CYCLES)) u_dbnc (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_sync),
        .dout (pin_filt)
    );

    gpio_irq_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .raw_lvl   (pin_sync),
        .filt_lvl  (pin_filt),
        .dbnc      (cfg.dbnc),
        .edge_sel  (cfg.edge_sel),
        .rise_high (cfg.rise_high),
        .enable    (cfg.enable),
        .ack_clr   (ack_clr),
        .status    (status)
    );

    assign ack_clr = (bus_wr && bus_addr == OFS_ACK) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_DATA: cfg.data      <= bus_wdata;
                OFS_DIR:  cfg.dir       <= bus_wdata;
                OFS_EDGE: cfg.edge_sel  <= bus_wdata;
                OFS_POL:  cfg.rise_high <= bus_wdata;
                OFS_EN:   cfg.enable    <= bus_wdata;
                OFS_DBNC: cfg.dbnc      <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = (cfg.data & cfg.dir) | (pin_sync & ~cfg.dir);
            OFS_DIR:  bus_rdata = cfg.dir;
            OFS_EDGE: bus_rdata = cfg.edge_sel;
            OFS_POL:  bus_rdata = cfg.rise_high;
            OFS_EN:   bus_rdata = cfg.enable;
            OFS_STAT: bus_rdata = status;
            OFS_DBNC: bus_rdata = cfg.dbnc;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out  = cfg.data;
    assign pin_oe   = cfg.dir;
    assign irq_pin  = status;
    assign irq_comb = |status;

    // R7: writing an all-zero enable silences the combined output
    assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == OFS_EN && bus_wdata == '0) |-> !irq_comb);

    // R3: output enables only move after a direction write
    assert_oe_stable_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr && bus_addr == OFS_DIR) |-> $stable(pin_oe));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DBC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, irq_pin;
    logic       irq_comb;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.DB_CYCLES(DBC)) u_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_comb(irq_comb)
    );

    // Behavioural reference: pin history queue, run-length counters, event set
    logic [7:0] r_data, r_dir, r_edge, r_pol, r_en, r_db, r_filt, r_prevdet, r_evt;
    logic [7:0] hist[$];
    int         run_len[8];

    function automatic logic [7:0] seen_pins();
        return (hist.size() >= 2) ? hist[0] : 8'h00;
    endfunction

    function automatic logic [7:0] det_view();
        return (r_db & r_filt) | (~r_db & seen_pins());
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] dv, lv;
        dv = det_view();
        lv = 8'h00;
        for (int b = 0; b < 8; b++) lv[b] = r_pol[b] ? dv[b] : ~dv[b];
        return r_en & ((r_edge & r_evt) | (~r_edge & lv));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            r_data = 0; r_dir = 0; r_edge = 0; r_pol = 0; r_en = 0; r_db = 0;
            r_filt = 0; r_prevdet = 0; r_evt = 0;
            hist.delete();
            for (int b = 0; b < 8; b++) run_len[b] = 0;
        end else begin : step
            logic [7:0] dv, ev, sp, nf;
            dv = det_view();
            sp = seen_pins();
            ev = 8'h00;
            for (int b = 0; b < 8; b++) begin
                if (r_edge[b]) begin
                    if (r_pol[b] && dv[b] && !r_prevdet[b]) ev[b] = 1'b1;
                    if (!r_pol[b] && !dv[b] && r_prevdet[b]) ev[b] = 1'b1;
                end
            end
            if (bus_wr && bus_addr == 8'h98) r_evt = r_evt & ~bus_wdata;
            r_evt = r_evt | ev;
            r_prevdet = dv;
            nf = r_filt;
            for (int b = 0; b < 8; b++) begin
                if (sp[b] == r_filt[b]) run_len[b] = 0;
                else begin
                    run_len[b]++;
                    if (run_len[b] >= DBC) begin nf[b] = sp[b]; run_len[b] = 0; end
                end
            end
            r_filt = nf;
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: r_data = bus_wdata;
                    8'h10: r_dir  = bus_wdata;
                    8'h90: r_edge = bus_wdata;
                    8'h94: r_pol  = bus_wdata;
                    8'h9C: r_en   = bus_wdata;
                    8'hA8: r_db   = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_back(pin_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk(irq_pin, exp_status(), "R10 irq_pin vs reference");
            chk({7'd0, irq_comb}, {7'd0, |exp_status()}, "R10 irq_comb vs reference");
            chk(pin_oe, r_dir, "R3 pin_oe");
            chk(pin_out, r_data, "R3 pin_out");
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic pins(input logic [7:0] v, input int hold);
        @(negedge clk);
        pin_in = v;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        rd(8'h00, 8'h00, "R2 reset data");
        rd(8'h10, 8'h00, "R2 reset dir");
        rd(8'h9C, 8'h00, "R2 reset enable");
        rd(8'hA0, 8'h00, "R2 reset status");
        chk(irq_pin, 8'h00, "R2 reset irq");

        // R3 direction and data read mix, R1 sync latency
        wr(8'h10, 8'hF0);
        wr(8'h00, 8'hA5);
        chk(pin_oe, 8'hF0, "R3 oe");
        @(negedge clk); pin_in = 8'h0C;
        @(negedge clk); #2; chk(bus_rdata & 8'h0F, 8'h00, "R1 one clock not yet visible");
        @(negedge clk); #2; chk(bus_rdata, 8'hAC, "R1 R3 data read after two clocks");
        rd(8'h98, 8'h00, "R2 ack reads zero");
        rd(8'h44, 8'h00, "R2 unmapped reads zero");
        wr(8'h10, 8'h00);
        pins(8'h00, 3);

        // R4 level-high on bit0, ack does not clear
        wr(8'h90, 8'h00);
        wr(8'h94, 8'h01);
        wr(8'h9C, 8'h01);
        pins(8'h01, 4);
        chk(irq_pin, 8'h01, "R4 level high active");
        wr(8'h98, 8'h01);
        @(negedge clk);
        chk(irq_pin, 8'h01, "R4 ack leaves level");
        pins(8'h00, 4);
        chk(irq_pin, 8'h00, "R4 level follows pin");

        // R5 rising edge on bit1, R6 partial ack
        wr(8'h90, 8'h06);
        wr(8'h94, 8'h02);
        wr(8'h9C, 8'h06);
        pins(8'h02, 1);
        pins(8'h00, 5);
        chk(irq_pin, 8'h02, "R5 rising edge latched");
        rd(8'hA0, 8'h02, "R7 status read");
        wr(8'h98, 8'hFD);
        chk(irq_pin, 8'h02, "R6 zero bit keeps event");
        wr(8'h98, 8'h02);
        chk(irq_pin, 8'h00, "R6 ack clears event");

        // R5 falling edge on bit2
        pins(8'h04, 5);
        chk(irq_pin, 8'h00, "R5 no fire on rise with falling polarity");
        pins(8'h00, 5);
        chk(irq_pin, 8'h04, "R5 falling edge latched");
        wr(8'h98, 8'h04);

        // R8 polarity flip emulating both edges on bit3
        wr(8'h90, 8'h08);
        wr(8'h94, 8'h08);
        wr(8'h9C, 8'h08);
        pins(8'h08, 5);
        chk(irq_pin, 8'h08, "R8 rising caught");
        wr(8'h94, 8'h00);
        wr(8'h98, 8'h08);
        chk(irq_pin, 8'h00, "R8 cleared before fall");
        pins(8'h00, 5);
        chk(irq_pin, 8'h08, "R8 falling caught after flip");

        // R7 enable gating
        wr(8'h9C, 8'h00);
        chk({7'd0, irq_comb}, 8'h00, "R7 disabled port silent");
        wr(8'h9C, 8'h08);
        chk(irq_pin, 8'h08, "R7 event visible again");
        wr(8'h98, 8'hFF);

        // R9 debounce on bit4
        wr(8'hA8, 8'h10);
        wr(8'h90, 8'h10);
        wr(8'h94, 8'h10);
        wr(8'h9C, 8'h10);
        pins(8'h10, 2);
        pins(8'h00, 10);
        chk(irq_pin, 8'h00, "R9 short pulse dropped");
        pins(8'h10, 12);
        chk(irq_pin, 8'h10, "R9 stable level passes");

        // R10 several pins at once
        wr(8'h98, 8'hFF);
        wr(8'hA8, 8'h00);
        wr(8'h90, 8'h60);
        wr(8'h94, 8'hE0);
        wr(8'h9C, 8'hE0);
        pins(8'hF0, 6);
        chk(irq_pin, 8'hE0, "R10 combined sources");
        chk({7'd0, irq_comb}, 8'h01, "R10 combined output");
        pins(8'h00, 6);
        chk(irq_pin, 8'h60, "R10 edge bits stay, level bit drops");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule